// File: doc/BRIEF.md
# Capture Reload Timer with Baud Output

This block is a 16-bit timer/counter whose count is held as two byte registers, a high byte and a low byte. In timer function it advances once on each machine-cycle enable. In counter function it advances on falling edges of an external count pin. The count pin is sampled once per machine cycle. A single counter serves one of three jobs at a time. In capture mode it copies its running count into a 16-bit capture/reload register when an external trigger falls. In auto-reload mode it reloads from that register on overflow, and it can also count down with the direction taken from the trigger pin level. In baud mode its overflows become one-clock pulses that a serial port can use as its receive and transmit clocks.

Software reaches the block through a plain byte-wide write port and a registered read port. Two sticky flags report a 16-bit overflow and an accepted trigger event. The hardware only sets these flags, and only software clears them. The machine-cycle strobe and the pin timing come from outside the block.

Top module: `crt_timer16`

## Requirements
- R1: After a synchronous reset, every register reads zero, both flags are low, both baud pulses are low and `rd_data` is zero.
- R2: Register addresses are as follows. 0 is control, 1 is count low byte, 2 is count high byte, 3 is capture/reload low byte, 4 is capture/reload high byte, and 5 holds the down-count enable in bit 0. Control bits are run=0, counter-function select=1, capture-mode select=2, trigger enable=3, receive-clock enable=4, transmit-clock enable=5, trigger flag=6, overflow flag=7. `rd_data` shows the addressed register one clock after `rd_addr` is applied. Unused addresses read zero.
- R3: In timer function with run set, each `mc_en` cycle increments the low byte, and a carry out of the low byte increments the high byte. With run clear, the count, the capture/reload register and the flags stay unchanged.
- R4: In counter function, the count advances only when the count pin was sampled 1 at one `mc_en` and 0 at the next. A pulse that starts and ends between two `mc_en` cycles is not counted.
- R5: In capture mode an increment from 0xFFFF gives 0x0000 and sets the overflow flag. A trigger event copies the count as it was before that cycle into the capture/reload register and sets the trigger flag, and counting continues.
- R6: In auto-reload mode with down-count disabled, an increment from 0xFFFF loads the capture/reload value and sets the overflow flag. A trigger event loads the capture/reload value and sets the trigger flag, and it overrides the increment in that cycle.
- R7: In auto-reload mode with down-count enabled, a high trigger pin counts up (0xFFFF reloads, as in R6). A low trigger pin counts down, and a count equal to the capture/reload value becomes 0xFFFF and sets the overflow flag. Trigger falling edges cause no reload and leave the trigger flag unchanged.
- R8: With either clock enable set (baud mode), an increment from 0xFFFF loads the capture/reload value without setting the overflow flag. `rx_baud` and `tx_baud` go high for exactly the clock after that edge, each only when its own enable is set. Overflows outside baud mode give no pulse.
- R9: A trigger event is a falling edge of the trigger pin between two `mc_en` samples, taken with trigger enable and run set. In baud mode trigger events are blocked: no capture, no reload, no trigger flag.
- R10: Both flags are sticky. A control write with a 0 in a flag bit clears it, and a 1 has no effect. A hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle enable strobe |
| cnt_pin | input | 1 | External count input (counter function) |
| trig_pin | input | 1 | External trigger input; direction level in down-count mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | BYTE_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | BYTE_W | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky trigger-event flag |
| rx_baud | output | 1 | One-clock receive clock pulse |
| tx_baud | output | 1 | One-clock transmit clock pulse |

## Verification
The bench targets the wrap boundaries. These are the carry from 0x00FF into the high byte, 0xFFFF in each mode, and down-counting onto the reload value. A design that treated the down-count compare as "below" instead of "equal" would skip the reload. A design that set the overflow flag in baud mode would break R8. A pin pulse hidden between two machine cycles must not count, and an edge-every-clock design would count it. A trigger in baud mode or in down-count mode must leave the capture/reload register and the trigger flag unchanged. A capture must hold the pre-increment count, so a design that captured the post-increment value would read one too high. The tests also cover the flag write rules, where a design that let software set a flag would fail.

// File: rtl/crt_pkg.sv
package crt_pkg;
  // register addresses
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_CNT_LO = 1;
  localparam int unsigned REG_CNT_HI = 2;
  localparam int unsigned REG_CR_LO  = 3;
  localparam int unsigned REG_CR_HI  = 4;
  localparam int unsigned REG_DIR    = 5;
  // control bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_CSEL = 1;
  localparam int unsigned CB_CAP  = 2;
  localparam int unsigned CB_TEN  = 3;
  localparam int unsigned CB_RXE  = 4;
  localparam int unsigned CB_TXE  = 5;
  localparam int unsigned CB_EXT  = 6;
  localparam int unsigned CB_OVF  = 7;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_BAUD    = 2'd2
  } crt_mode_e;
endpackage

// File: rtl/crt_fall_det.sv
module crt_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic pin,
  output logic fall
);
  logic smp_q;

  always_ff @(posedge clk) begin
    if (rst)            smp_q <= 1'b0;
    else if (sample_en) smp_q <= pin;
  end

  // previous machine-cycle sample high, current one low
  assign fall = sample_en & smp_q & ~pin;
endmodule

// File: rtl/crt_core.sv
module crt_core
  import crt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mc_en,
  input  logic                run,
  input  logic                cnt_sel,
  input  logic                cnt_fall,
  input  logic                trig_fall,
  input  logic                trig_lvl,
  input  logic                trig_en,
  input  logic                dir_en,
  input  logic                rx_en,
  input  logic                tx_en,
  input  crt_mode_e           mode,
  input  logic                wr_cnt_lo,
  input  logic                wr_cnt_hi,
  input  logic                wr_cr_lo,
  input  logic                wr_cr_hi,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] reload,
  output logic                ovf_set,
  output logic                ext_set,
  output logic                rx_pulse,
  output logic                tx_pulse
);
  localparam int CW = 2 * BYTE_W;

  logic [BYTE_W-1:0] cnt_lo_q, cnt_hi_q, cr_lo_q, cr_hi_q;
  logic [BYTE_W-1:0] lo_inc, hi_inc, lo_dec, hi_dec;
  logic              lo_carry, lo_borrow;
  logic [CW-1:0]     cnt_q, cr_q, cnt_d;
  logic              tick, down, at_max, trig_evt, baud_ovf;

  assign cnt_q = {cnt_hi_q, cnt_lo_q};
  assign cr_q  = {cr_hi_q, cr_lo_q};

  assign tick   = run & mc_en & (cnt_sel ? cnt_fall : 1'b1);
  assign down   = (mode == MODE_RELOAD) & dir_en & ~trig_lvl;
  assign at_max = &cnt_q;

  // trigger blocked while clocking the serial port and in down-count mode
  assign trig_evt = run & trig_en & trig_fall & (mode != MODE_BAUD) &
                    ~((mode == MODE_RELOAD) & dir_en);

  // byte-wise increment and decrement
  assign {lo_carry, lo_inc} = {1'b0, cnt_lo_q} + (BYTE_W+1)'(1);
  assign hi_inc    = cnt_hi_q + {{(BYTE_W-1){1'b0}}, lo_carry};
  assign lo_borrow = (cnt_lo_q == '0);
  assign lo_dec    = cnt_lo_q - BYTE_W'(1);
  assign hi_dec    = cnt_hi_q - {{(BYTE_W-1){1'b0}}, lo_borrow};

  always_comb begin
    cnt_d    = cnt_q;
    ovf_set  = 1'b0;
    baud_ovf = 1'b0;
    if (tick) begin
      if (down) begin
        if (cnt_q == cr_q) begin
          cnt_d   = '1;
          ovf_set = 1'b1;
        end else begin
          cnt_d = {hi_dec, lo_dec};
        end
      end else if (at_max) begin
        unique case (mode)
          MODE_BAUD: begin
            cnt_d    = cr_q;
            baud_ovf = 1'b1;
          end
          MODE_CAPTURE: begin
            cnt_d   = '0;
            ovf_set = 1'b1;
          end
          default: begin
            cnt_d   = cr_q;
            ovf_set = 1'b1;
          end
        endcase
      end else begin
        cnt_d = {hi_inc, lo_inc};
      end
    end
    if (trig_evt && mode == MODE_RELOAD) cnt_d = cr_q;
  end

  assign ext_set = trig_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
      cr_lo_q  <= '0;
      cr_hi_q  <= '0;
      rx_pulse <= 1'b0;
      tx_pulse <= 1'b0;
    end else begin
      cnt_lo_q <= wr_cnt_lo ? wdata : cnt_d[BYTE_W-1:0];
      cnt_hi_q <= wr_cnt_hi ? wdata : cnt_d[CW-1:BYTE_W];
      if (wr_cr_lo)                                     cr_lo_q <= wdata;
      else if (trig_evt && mode == MODE_CAPTURE)        cr_lo_q <= cnt_lo_q;
      if (wr_cr_hi)                                     cr_hi_q <= wdata;
      else if (trig_evt && mode == MODE_CAPTURE)        cr_hi_q <= cnt_hi_q;
      rx_pulse <= baud_ovf & rx_en;
      tx_pulse <= baud_ovf & tx_en;
    end
  end

  assign count  = cnt_q;
  assign reload = cr_q;
endmodule

// File: rtl/crt_timer16.sv
module crt_timer16
  import crt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              rx_baud,
  output logic              tx_baud
);
  localparam int CW    = 2 * BYTE_W;
  localparam int NPINS = 2;

  logic              run, cnt_sel, cap_mode, trig_en, rx_en, tx_en, dir_en;
  logic              wr_ctrl, wr_dir;
  logic              ovf_set, ext_set;
  logic [NPINS-1:0]  pins, falls;
  logic [CW-1:0]     count, reload;
  logic [BYTE_W-1:0] ctrl_view, rd_d;
  crt_mode_e         mode;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign wr_dir  = wr_en && (wr_addr == ADDR_W'(REG_DIR));

  // control and flag registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; cnt_sel <= 1'b0; cap_mode <= 1'b0; trig_en <= 1'b0;
      rx_en <= 1'b0; tx_en <= 1'b0; dir_en <= 1'b0;
      ovf_flag <= 1'b0; ext_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run      <= wr_data[CB_RUN];
        cnt_sel  <= wr_data[CB_CSEL];
        cap_mode <= wr_data[CB_CAP];
        trig_en  <= wr_data[CB_TEN];
        rx_en    <= wr_data[CB_RXE];
        tx_en    <= wr_data[CB_TXE];
      end
      if (wr_dir) dir_en <= wr_data[0];
      ovf_flag <= ovf_set | (ovf_flag & ~(wr_ctrl & ~wr_data[CB_OVF]));
      ext_flag <= ext_set | (ext_flag & ~(wr_ctrl & ~wr_data[CB_EXT]));
    end
  end

  always_comb begin
    if (rx_en || tx_en) mode = MODE_BAUD;
    else if (cap_mode)  mode = MODE_CAPTURE;
    else                mode = MODE_RELOAD;
  end

  // falling-edge detectors for count pin (0) and trigger pin (1)
  assign pins = {trig_pin, cnt_pin};
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_det
    crt_fall_det u_det (
      .clk       (clk),
      .rst       (rst),
      .sample_en (mc_en),
      .pin       (pins[gi]),
      .fall      (falls[gi])
    );
  end

  crt_core #(.BYTE_W(BYTE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mc_en     (mc_en),
    .run       (run),
    .cnt_sel   (cnt_sel),
    .cnt_fall  (falls[0]),
    .trig_fall (falls[1]),
    .trig_lvl  (trig_pin),
    .trig_en   (trig_en),
    .dir_en    (dir_en),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .mode      (mode),
    .wr_cnt_lo (wr_en && (wr_addr == ADDR_W'(REG_CNT_LO))),
    .wr_cnt_hi (wr_en && (wr_addr == ADDR_W'(REG_CNT_HI))),
    .wr_cr_lo  (wr_en && (wr_addr == ADDR_W'(REG_CR_LO))),
    .wr_cr_hi  (wr_en && (wr_addr == ADDR_W'(REG_CR_HI))),
    .wdata     (wr_data),
    .count     (count),
    .reload    (reload),
    .ovf_set   (ovf_set),
    .ext_set   (ext_set),
    .rx_pulse  (rx_baud),
    .tx_pulse  (tx_baud)
  );

  // registered read port
  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_RUN]  = run;
    ctrl_view[CB_CSEL] = cnt_sel;
    ctrl_view[CB_CAP]  = cap_mode;
    ctrl_view[CB_TEN]  = trig_en;
    ctrl_view[CB_RXE]  = rx_en;
    ctrl_view[CB_TXE]  = tx_en;
    ctrl_view[CB_EXT]  = ext_flag;
    ctrl_view[CB_OVF]  = ovf_flag;
    case (rd_addr)
      ADDR_W'(REG_CTRL):   rd_d = ctrl_view;
      ADDR_W'(REG_CNT_LO): rd_d = count[BYTE_W-1:0];
      ADDR_W'(REG_CNT_HI): rd_d = count[CW-1:BYTE_W];
      ADDR_W'(REG_CR_LO):  rd_d = reload[BYTE_W-1:0];
      ADDR_W'(REG_CR_HI):  rd_d = reload[CW-1:BYTE_W];
      ADDR_W'(REG_DIR):    rd_d = {{(BYTE_W-1){1'b0}}, dir_en};
      default:             rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end
endmodule

// File: rtl/crt_timer16_chk.sv
module crt_timer16_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              mc_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic              rx_baud,
  input logic              tx_baud,
  input logic              rx_en,
  input logic              tx_en,
  input logic              run,
  input logic [2*BYTE_W-1:0] count
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(0));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !wr_ctrl) |=> ovf_flag);

  // R10
  ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_flag && !wr_ctrl) |=> ext_flag);

  // R9
  baud_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((rx_en || tx_en) && !ext_flag) |=> !ext_flag);

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_baud |-> ($past(mc_en) && $past(rx_en)));

  // R8
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_baud |-> ($past(mc_en) && $past(tx_en)));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(count));
endmodule

bind crt_timer16 crt_timer16_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mc_en    (mc_en),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .ovf_flag (ovf_flag),
  .ext_flag (ext_flag),
  .rx_baud  (rx_baud),
  .tx_baud  (tx_baud),
  .rx_en    (rx_en),
  .tx_en    (tx_en),
  .run      (run),
  .count    (count)
);

// File: tb/sim_crt_timer16.sv
module sim_crt_timer16;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int BW = 8;

  typedef struct packed {
    logic [15:0] tag;
    logic [7:0]  ctrl;
    logic        dir;
    logic        trig;
    logic [15:0] cnt;
    logic [15:0] cr;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{"R3", 8'h05, 1'b0, 1'b0, 16'h00FE, 16'h0000, 8'd3, 16'h0101, 1'b0},
    '{"R5", 8'h05, 1'b0, 1'b0, 16'hFFFE, 16'h0000, 8'd3, 16'h0001, 1'b1},
    '{"R6", 8'h01, 1'b0, 1'b0, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 1'b1},
    '{"R7", 8'h01, 1'b1, 1'b0, 16'h0012, 16'h0010, 8'd3, 16'hFFFF, 1'b1},
    '{"R7", 8'h01, 1'b1, 1'b1, 16'hFFFF, 16'h00AA, 8'd1, 16'h00AA, 1'b1},
    '{"R8", 8'h31, 1'b0, 1'b0, 16'hFFFE, 16'hFFFC, 8'd3, 16'hFFFD, 1'b0},
    '{"R3", 8'h04, 1'b0, 1'b0, 16'h5555, 16'h0000, 8'd4, 16'h5555, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, mc_en = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [BW-1:0] wr_data = '0;
  logic [BW-1:0] rd_data;
  logic ovf_flag, ext_flag, rx_baud, tx_baud;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crt_timer16 #(.BYTE_W(BW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .mc_en(mc_en), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .rx_baud(rx_baud), .tx_baud(tx_baud)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); d = rd_data;
  endtask

  task automatic rd16(input int a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 1, hi);
    d = {hi, lo};
  endtask

  task automatic mc();
    @(negedge clk); mc_en = 1'b1;
    @(negedge clk); mc_en = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c, input logic d, input logic [15:0] cn, input logic [15:0] r);
    wr(0, c); wr(5, {7'b0, d});
    wr(1, cn[7:0]); wr(2, cn[15:8]); wr(3, r[7:0]); wr(4, r[15:8]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    chk("R1 rd_data", {8'h0, rd_data}, 16'h0);
    chk("R1 pulses/flags", {12'h0, ovf_flag, ext_flag, rx_baud, tx_baud}, 16'h0);
    rd(0, b); chk("R1 ctrl", {8'h0, b}, 16'h0);
    rd16(1, w); chk("R1 count", w, 16'h0);
    rd16(3, w); chk("R1 reload", w, 16'h0);

    // R2 register readback
    wr(3, 8'hEF); wr(4, 8'hBE); wr(5, 8'h01);
    rd16(3, w); chk("R2 reload readback", w, 16'hBEEF);
    rd(5, b); chk("R2 dir readback", {8'h0, b}, 16'h0001);
    rd(6, b); chk("R2 unused addr", {8'h0, b}, 16'h0);
    wr(5, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      trig_pin = VECS[i].trig;
      setup(VECS[i].ctrl, VECS[i].dir, VECS[i].cnt, VECS[i].cr);
      for (int t = 0; t < int'(VECS[i].ticks); t++) mc();
      rd16(1, w); chk({string'(VECS[i].tag), " count"}, w, VECS[i].exp_cnt);
      rd(0, b);   chk({string'(VECS[i].tag), " ovf flag"}, {15'h0, b[7]}, {15'h0, VECS[i].exp_ovf});
    end

    // R4 counter function with a hidden pulse
    trig_pin = 1'b0;
    setup(8'h03, 1'b0, 16'h0000, 16'h0000);
    cnt_pin = 1'b1; mc(); cnt_pin = 1'b0; mc(); mc();
    cnt_pin = 1'b1; mc(); cnt_pin = 1'b0; mc();
    @(negedge clk); cnt_pin = 1'b1; repeat (3) @(negedge clk); cnt_pin = 1'b0;
    mc();
    rd16(1, w); chk("R4 edge count", w, 16'h0002);

    // R5 capture on trigger fall
    setup(8'h0D, 1'b0, 16'h0100, 16'h0000);
    trig_pin = 1'b1; mc(); trig_pin = 1'b0; mc();
    rd16(1, w); chk("R5 count continues", w, 16'h0102);
    rd16(3, w); chk("R5 captured value", w, 16'h0101);
    rd(0, b);   chk("R5 trigger flag", {8'h0, b}, 16'h004D);

    // R10 flag write rules
    wr(0, 8'h0D); rd(0, b); chk("R10 clear by 0", {8'h0, b}, 16'h000D);
    wr(0, 8'hCD); rd(0, b); chk("R10 write 1 no set", {8'h0, b}, 16'h000D);
    setup(8'h05, 1'b0, 16'hFFFF, 16'h0000);
    mc(); mc(); mc();
    rd(0, b); chk("R10 overflow sticky", {8'h0, b}, 16'h0085);
    wr(0, 8'h05); rd(0, b); chk("R10 overflow cleared", {8'h0, b}, 16'h0005);

    // R6 trigger reload overrides increment
    setup(8'h09, 1'b0, 16'h0005, 16'h4321);
    trig_pin = 1'b1; mc(); trig_pin = 1'b0; mc();
    rd16(1, w); chk("R6 trigger reload", w, 16'h4321);
    rd(0, b);   chk("R6 trigger flag", {8'h0, b}, 16'h0049);

    // R7 trigger pin acts only as direction
    setup(8'h09, 1'b1, 16'h0050, 16'h0000);
    trig_pin = 1'b1; mc(); trig_pin = 1'b0; mc();
    rd16(1, w); chk("R7 up then down", w, 16'h0050);
    rd(0, b);   chk("R7 no trigger flag", {8'h0, b}, 16'h0009);

    // R9 trigger blocked in baud mode
    setup(8'h39, 1'b0, 16'h2000, 16'h1111);
    trig_pin = 1'b1; mc(); trig_pin = 1'b0; mc();
    rd16(1, w); chk("R9 baud count", w, 16'h2002);
    rd16(3, w); chk("R9 reload untouched", w, 16'h1111);
    rd(0, b);   chk("R9 no trigger flag", {8'h0, b}, 16'h0039);

    // R8 baud pulse timing and routing
    setup(8'h11, 1'b0, 16'hFFFF, 16'hFFF0);
    mc();
    chk("R8 rx pulse", {14'h0, rx_baud, tx_baud}, 16'h0002);
    @(negedge clk);
    chk("R8 rx one clock", {14'h0, rx_baud, tx_baud}, 16'h0000);
    setup(8'h21, 1'b0, 16'hFFFF, 16'hFFF0);
    mc();
    chk("R8 tx pulse", {14'h0, rx_baud, tx_baud}, 16'h0001);
    rd16(1, w); chk("R8 baud reload", w, 16'hFFF0);
    setup(8'h05, 1'b0, 16'hFFFF, 16'h0000);
    mc();
    chk("R8 no pulse outside baud", {14'h0, rx_baud, tx_baud}, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule